// File: doc/BRIEF.md
# Timestamp Lease Coherence Controller

This block manages coherence for lines of a shared cache used by a few cores. It does not keep a list of sharers. It orders operations in logical time instead. Each core has a program timestamp. Each line has a lease end, a write time and an optional owner. A read grants a lease up to a future logical time. A write moves the writer's time past every lease already granted on that line. No sharer is told to drop its copy.

Requests come in one at a time on a valid/ready channel. Each request names a core, a line, an operation and, for a write, the line data. Each accepted request produces one response pulse. The response carries the line data, the line's lease end and the core's updated timestamp. Suppose a core other than the owner touches a line that has an owner. The controller first sends a writeback request to the owner and stalls the request channel. It continues once the owner returns the line.

Top module: `tslease_ctrl`

## Requirements
- R1: After reset every core timestamp, every line lease end, every line write time and all line data are zero, and no line has an owner. `req_ready` is high and `resp_valid` and `wb_req_valid` are low.
- R2: A read (`req_op` 0) or renewal (`req_op` 2) on a line with no owner returns the stored data. The core's new timestamp is the larger of its own timestamp and the line's write time. The lease end becomes the larger of the old lease end and that timestamp plus LEASE (default 10).
- R3: A grant never lowers a line's lease end. A requester whose timestamp plus LEASE falls below the current lease end receives the current lease end.
- R4: A write (`req_op` 1) stores the write data. It sets the writer's timestamp to the larger of its own timestamp and the line's lease end plus one. It sets the line's lease end and write time to that value, and makes the writer the line's owner.
- R5: A write to a line with no owner issues no writeback or other message to cores that hold leases on it.
- R6: A read, renewal or write from a core that is not the owner of an owned line raises `wb_req_valid`. The request names the owner in `wb_req_core` and the line in `wb_req_line`. `req_ready` stays low until `wb_ack_valid` is seen.
- R7: When the writeback is acknowledged, the line takes the data from `wb_ack_data` and loses its owner. The waiting request is then served as in R2 or R4, so a reader's timestamp reaches at least the owner's last write time.
- R8: A read or renewal from the line's owner is served at once by the rule of R2, with no writeback.
- R9: A write from the line's owner issues no writeback. It only advances the owner's timestamp and the line's times by the rule of R4.
- R10: `resp_valid` rises for one cycle on the clock edge that accepts a request needing no writeback, or on the edge that samples `wb_ack_valid`. `resp_core` names the requester.
- R11: On any line, the timestamp of a write is greater than the lease end returned by every earlier read of that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_core | input | CW | Requesting core |
| req_op | input | 2 | 0 read, 1 write, 2 renewal |
| req_line | input | LW | Target line |
| req_wdata | input | DW | Write data |
| resp_valid | output | 1 | Response pulse |
| resp_core | output | CW | Core the response is for |
| resp_data | output | DW | Line data |
| resp_lease | output | TSW | Line lease end after the request |
| resp_ts | output | TSW | Core timestamp after the request |
| wb_req_valid | output | 1 | Writeback requested from owner |
| wb_req_core | output | CW | Owner asked to write back |
| wb_req_line | output | LW | Line to write back |
| wb_ack_valid | input | 1 | Owner returns the line |
| wb_ack_data | input | DW | Line data from owner |

## Verification
The assertions expect that `wb_ack_valid` is raised only while `wb_req_valid` is high. They also expect timestamps to stay far below the saturation value, so that strict ordering holds between writes and leases. The bench's owner model answers a writeback only after it sees the request. It replies two cycles later, for exactly one cycle. The bench issues a few dozen requests, so every timestamp stays in the tens.

// File: rtl/tslease_ctrl.sv
module tslease_ctrl #(
  parameter int NCORE = 4,
  parameter int NLINE = 8,
  parameter int DW    = 32,
  parameter int TSW   = 32,
  parameter int LEASE = 10,
  localparam int CW   = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int LW   = (NLINE > 1) ? $clog2(NLINE) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [CW-1:0]  req_core,
  input  logic [1:0]     req_op,
  input  logic [LW-1:0]  req_line,
  input  logic [DW-1:0]  req_wdata,
  output logic           resp_valid,
  output logic [CW-1:0]  resp_core,
  output logic [DW-1:0]  resp_data,
  output logic [TSW-1:0] resp_lease,
  output logic [TSW-1:0] resp_ts,
  output logic           wb_req_valid,
  output logic [CW-1:0]  wb_req_core,
  output logic [LW-1:0]  wb_req_line,
  input  logic           wb_ack_valid,
  input  logic [DW-1:0]  wb_ack_data
);
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [TSW-1:0] LEASE_T = TSW'(LEASE);
  localparam logic [TSW-1:0] ONE_T = TSW'(1);

  typedef enum logic {S_IDLE, S_WB} st_t;

  function automatic logic [TSW-1:0] sat_add(input logic [TSW-1:0] a, input logic [TSW-1:0] b);
    logic [TSW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[TSW] ? '1 : s[TSW-1:0];
  endfunction

  st_t             st;
  logic [DW-1:0]   mem    [NLINE];
  logic [TSW-1:0]  rts    [NLINE];
  logic [TSW-1:0]  wts    [NLINE];
  logic            own_v  [NLINE];
  logic [CW-1:0]   own_id [NLINE];
  logic [TSW-1:0]  pts    [NCORE];

  logic [CW-1:0]   cur_core, wb_core_q;
  logic [1:0]      cur_op;
  logic [LW-1:0]   cur_line;
  logic [DW-1:0]   cur_wdata;
  logic            rsp_wr_q;
  logic [TSW-1:0]  w_rt_q;

  logic [CW-1:0]   in_core;
  logic [1:0]      in_op;
  logic [LW-1:0]   in_line;
  logic [DW-1:0]   in_wdata, line_data;
  logic [TSW-1:0]  pt, rt, wt, rd_ts, ext, rd_lease, bump, wr_ts;
  logic            owned_other, take, need_wb, serve, is_wr;

  assign req_ready    = (st == S_IDLE);
  assign wb_req_valid = (st == S_WB);
  assign wb_req_core  = wb_core_q;
  assign wb_req_line  = cur_line;

  assign in_core  = (st == S_WB) ? cur_core  : req_core;
  assign in_op    = (st == S_WB) ? cur_op    : req_op;
  assign in_line  = (st == S_WB) ? cur_line  : req_line;
  assign in_wdata = (st == S_WB) ? cur_wdata : req_wdata;
  assign line_data = (st == S_WB) ? wb_ack_data : mem[in_line];

  assign owned_other = own_v[in_line] && (own_id[in_line] != in_core);
  assign take    = req_valid && req_ready;
  assign need_wb = take && owned_other;
  assign serve   = (take && !owned_other) || (st == S_WB && wb_ack_valid);
  assign is_wr   = (in_op == OP_WRITE);

  assign pt = pts[in_core];
  assign rt = rts[in_line];
  assign wt = wts[in_line];
  assign rd_ts    = (pt > wt) ? pt : wt;
  assign ext      = sat_add(rd_ts, LEASE_T);
  assign rd_lease = (ext > rt) ? ext : rt;
  assign bump     = sat_add(rt, ONE_T);
  assign wr_ts    = (pt > bump) ? pt : bump;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      for (int i = 0; i < NLINE; i++) begin
        mem[i]    <= '0;
        rts[i]    <= '0;
        wts[i]    <= '0;
        own_v[i]  <= 1'b0;
        own_id[i] <= '0;
      end
      for (int c = 0; c < NCORE; c++) pts[c] <= '0;
      cur_core   <= '0;
      cur_op     <= '0;
      cur_line   <= '0;
      cur_wdata  <= '0;
      wb_core_q  <= '0;
      resp_valid <= 1'b0;
      resp_core  <= '0;
      resp_data  <= '0;
      resp_lease <= '0;
      resp_ts    <= '0;
      rsp_wr_q   <= 1'b0;
      w_rt_q     <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (need_wb) begin
        st        <= S_WB;
        cur_core  <= req_core;
        cur_op    <= req_op;
        cur_line  <= req_line;
        cur_wdata <= req_wdata;
        wb_core_q <= own_id[req_line];
      end
      if (serve) begin
        st         <= S_IDLE;
        resp_valid <= 1'b1;
        resp_core  <= in_core;
        rsp_wr_q   <= is_wr;
        w_rt_q     <= rt;
        if (is_wr) begin
          mem[in_line]    <= in_wdata;
          pts[in_core]    <= wr_ts;
          rts[in_line]    <= wr_ts;
          wts[in_line]    <= wr_ts;
          own_v[in_line]  <= 1'b1;
          own_id[in_line] <= in_core;
          resp_data       <= in_wdata;
          resp_lease      <= wr_ts;
          resp_ts         <= wr_ts;
        end else begin
          mem[in_line] <= line_data;
          if (st == S_WB) own_v[in_line] <= 1'b0;
          pts[in_core] <= rd_ts;
          rts[in_line] <= rd_lease;
          resp_data    <= line_data;
          resp_lease   <= rd_lease;
          resp_ts      <= rd_ts;
        end
      end
    end
  end

  p_wb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req_valid && !wb_ack_valid |=> wb_req_valid && !req_ready && $stable(wb_req_core) && $stable(wb_req_line));

  p_lease_covers_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !rsp_wr_q |-> resp_lease >= resp_ts);

  p_write_past_lease_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && rsp_wr_q && (w_rt_q != '1) |-> resp_ts > w_rt_q);

  p_owner_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take && own_v[req_line] && (own_id[req_line] == req_core) |=> !wb_req_valid && resp_valid);

  generate
    for (genvar c = 0; c < NCORE; c++) begin : g_core_chk
      p_pts_mono_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pts[c] >= $past(pts[c]));
    end
    for (genvar l = 0; l < NLINE; l++) begin : g_line_chk
      p_lease_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rts[l] >= $past(rts[l]));
    end
  endgenerate
endmodule

// File: tb/sim_tslease_ctrl.sv
module sim_tslease_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_core = '0;
  logic [1:0]  req_op = '0;
  logic [2:0]  req_line = '0;
  logic [31:0] req_wdata = '0;
  logic        resp_valid;
  logic [1:0]  resp_core;
  logic [31:0] resp_data, resp_lease, resp_ts;
  logic        wb_req_valid;
  logic [1:0]  wb_req_core;
  logic [2:0]  wb_req_line;
  logic        wb_ack_valid = 1'b0;
  logic [31:0] wb_ack_data = '0;

  tslease_ctrl u0 (.*);

  int n_run = 0, n_fail = 0;
  int wb_cnt = 0;
  logic [1:0] wb_seen_core;
  logic [2:0] wb_seen_line;
  logic wb_ready_low;
  logic [31:0] g_data, g_lease, g_ts;
  logic [1:0] g_core;
  int g_wait;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (wb_req_valid) begin
      wb_cnt++;
      wb_seen_core = wb_req_core;
      wb_seen_line = wb_req_line;
      repeat (2) @(negedge clk);
      wb_ready_low = !req_ready && wb_req_valid;
      wb_ack_data = {16'hD00D, 6'd0, wb_seen_core, 5'd0, wb_seen_line};
      wb_ack_valid = 1'b1;
      @(negedge clk);
      wb_ack_valid = 1'b0;
    end
  end

  task automatic issue(input logic [1:0] core, input logic [1:0] op, input logic [2:0] line,
                       input logic [31:0] wd);
    bit acc;
    @(negedge clk);
    req_valid = 1'b1; req_core = core; req_op = op; req_line = line; req_wdata = wd;
    do begin
      acc = req_ready;
      @(posedge clk);
      if (!acc) @(negedge clk);
    end while (!acc);
    g_wait = 0;
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      g_wait++;
      if (resp_valid) break;
    end
    g_data = resp_data; g_lease = resp_lease; g_ts = resp_ts; g_core = resp_core;
    @(negedge clk);
    chk("R10 pulse", {31'd0, resp_valid}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    chk("R1 resp_valid", {31'd0, resp_valid}, 32'd0);
    chk("R1 wb_req_valid", {31'd0, wb_req_valid}, 32'd0);
  endtask

  task automatic t_first_reads;
    issue(2'd0, 2'd0, 3'd1, 32'h0);
    chk("R1 data", g_data, 32'h0);
    chk("R1 ts", g_ts, 32'd0);
    chk("R2 lease", g_lease, 32'd10);
    chk("R10 latency", g_wait, 32'd1);
    chk("R10 core", {30'd0, g_core}, 32'd0);
    issue(2'd1, 2'd2, 3'd1, 32'h0);
    chk("R2 renew lease", g_lease, 32'd10);
    chk("R10 core", {30'd0, g_core}, 32'd1);
    issue(2'd2, 2'd0, 3'd1, 32'h0);
    chk("R2 lease shared", g_lease, 32'd10);
  endtask

  task automatic t_write_shared;
    int w0 = wb_cnt;
    issue(2'd3, 2'd1, 3'd1, 32'hA5);
    chk("R4 ts", g_ts, 32'd11);
    chk("R4 lease", g_lease, 32'd11);
    chk("R11 ts above lease 10", {31'd0, g_ts > 32'd10}, 32'd1);
    chk("R5 no writeback", wb_cnt, w0);
    chk("R10 latency", g_wait, 32'd1);
  endtask

  task automatic t_owner_ops;
    int w0 = wb_cnt;
    issue(2'd3, 2'd2, 3'd1, 32'h0);
    chk("R8 data", g_data, 32'hA5);
    chk("R8 ts", g_ts, 32'd11);
    chk("R8 lease", g_lease, 32'd21);
    chk("R8 latency", g_wait, 32'd1);
    issue(2'd3, 2'd1, 3'd1, 32'h5A);
    chk("R9 ts", g_ts, 32'd22);
    chk("R9 data", g_data, 32'h5A);
    chk("R9 no writeback", wb_cnt, w0);
  endtask

  task automatic t_remote_read;
    int w0 = wb_cnt;
    issue(2'd0, 2'd2, 3'd1, 32'h0);
    chk("R6 wb issued", wb_cnt, w0 + 1);
    chk("R6 wb core", {30'd0, wb_seen_core}, 32'd3);
    chk("R6 wb line", {29'd0, wb_seen_line}, 32'd1);
    chk("R6 ready low", {31'd0, wb_ready_low}, 32'd1);
    chk("R7 data", g_data, 32'hD00D0301);
    chk("R7 ts", g_ts, 32'd22);
    chk("R7 lease", g_lease, 32'd32);
    chk("R10 latency", g_wait, 32'd4);
    issue(2'd1, 2'd0, 3'd1, 32'h0);
    chk("R7 owner cleared", wb_cnt, w0 + 1);
    chk("R7 stored data", g_data, 32'hD00D0301);
    chk("R2 ts from write time", g_ts, 32'd22);
  endtask

  task automatic t_lease_floor_and_remote_write;
    int w0;
    issue(2'd3, 2'd0, 3'd2, 32'h0);
    chk("R2 lease", g_lease, 32'd32);
    issue(2'd2, 2'd1, 3'd5, 32'h11);
    chk("R4 fresh line ts", g_ts, 32'd1);
    issue(2'd2, 2'd0, 3'd2, 32'h0);
    chk("R3 ts", g_ts, 32'd1);
    chk("R3 lease kept", g_lease, 32'd32);
    w0 = wb_cnt;
    issue(2'd0, 2'd1, 3'd5, 32'h22);
    chk("R6 wb on write", wb_cnt, w0 + 1);
    chk("R6 wb core", {30'd0, wb_seen_core}, 32'd2);
    chk("R4 ts after wb", g_ts, 32'd22);
    chk("R11 ts above lease 1", {31'd0, g_ts > 32'd1}, 32'd1);
    issue(2'd0, 2'd0, 3'd5, 32'h0);
    chk("R8 new owner data", g_data, 32'h22);
    chk("R8 new owner no wb", wb_cnt, w0 + 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_reads();
    t_write_shared();
    t_owner_ops();
    t_remote_read();
    t_lease_floor_and_remote_write();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule